// File: doc/BRIEF.md
# Audio Output Clock Selector and Divider

This block generates the three output clocks of a digital audio receiver: a master clock at a chosen multiple of the sample rate, a bit clock at 64 times the sample rate, and a word clock at the sample rate itself. It has two clock inputs. One is the clock recovered by the receiver's PLL. The other is a local reference, either from a crystal or from an external source. While the PLL is not locked the reference drives all outputs. After lock has been held for a qualification interval, the block moves to the recovered clock. When lock is lost for long enough, it moves back.

The changeover is break-before-make. Each source's gate is enabled only after the other source's gate has been seen off through a two-flop synchronizer, so no output pulse is shorter than half a period of either source. After every changeover the bit and word dividers restart from a known phase.

A two-bit rate select sets the master clock multiple. The bit clock divider is derived from that multiple. Two further controls act on the master clock output only: one halves it and one inverts it. A status output reports which source is currently gated through.

Top module: `audio_clk_sel`

## Requirements
- R1: `rate_sel` encodes the master multiple as follows. 2'b01 means 256fs, 2'b10 means 384fs and 2'b11 means 512fs; in these three codes the gated source passes through unchanged. 2'b00 means the source runs in a 512fs band and is halved to 256fs. In every case the source clock is expected at the rate of that band.
- R2: The bit clock period is the master period times 4 for codes 00 and 01, times 6 for code 10 and times 8 for code 11. This keeps the bit clock at 64fs.
- R3: The word clock period is 64 bit clock periods. The word clock changes level only at a rising edge of the bit clock.
- R4: When the PLL is unlocked, the outputs are derived from `clk_ref`. When it is locked, they are derived from `clk_vco`.
- R5: The block moves to the recovered clock only after `pll_lock` has been held high for `LOCK_CYC` consecutive reference cycles, counted after a two-flop synchronizer.
- R6: The block moves back to the reference only after `pll_lock` has been low for `UNLOCK_CYC` consecutive reference cycles. A shorter dropout is ignored.
- R7: The two source gates are never open at the same time, and no master clock pulse is shorter than half a period of either source.
- R8: `half_en` = 1 doubles the master clock period and leaves the bit and word clocks unchanged.
- R9: `inv_en` = 1 inverts the master clock. With it clear, the master clock is high just after a rising bit clock edge; with it set, the master clock is low there.
- R10: On the first core edge after a source change, both the bit clock and the word clock restart high. The word clock then falls after 32 bit clock periods.
- R11: `on_vco` is 1 exactly while the recovered-clock gate is open. It changes on the same edge as that gate.
- R12: After reset, the reference is selected and `on_vco` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Local reference clock; also clocks lock qualification |
| clk_vco | input | 1 | Clock recovered by the PLL |
| rst | input | 1 | Synchronous active-high reset |
| pll_lock | input | 1 | PLL lock flag (asynchronous) |
| rate_sel | input | 2 | Master clock multiple select (static) |
| half_en | input | 1 | Halve the master clock output |
| inv_en | input | 1 | Invert the master clock output |
| mclk | output | 1 | Master clock output |
| bclk | output | 1 | Bit clock, 64fs |
| lrclk | output | 1 | Word clock, fs |
| on_vco | output | 1 | Recovered clock is the active source |

## Verification
The hardest situation to reach is the changeover window. In that window one gate is closing while the other has not yet opened, and a faulty handoff would show only as a runt pulse or an overlap lasting a fraction of a nanosecond. The stimulus runs the two sources at unrelated periods and toggles lock several times. Meanwhile a monitor records every master clock level change and keeps the shortest pulse width seen. Lock dropouts shorter than the unlock interval are driven next to the counter thresholds, so that both the hold-off and the switch-back can be seen on `on_vco`.

// File: rtl/acs_pkg.sv
`timescale 1ns/1ps
package acs_pkg;

    typedef enum logic [1:0] {
        RATE_HALF512 = 2'b00,
        RATE_256     = 2'b01,
        RATE_384     = 2'b10,
        RATE_512     = 2'b11
    } rate_e;

    localparam int LR_BITS  = 64;
    localparam int LR_W     = $clog2(LR_BITS);
    localparam int DIV_MAX  = 8;
    localparam int DIV_W    = $clog2(DIV_MAX + 1);

    typedef struct packed {
        logic bclk;
        logic lrclk;
    } frame_clk_t;

    typedef struct packed {
        logic ref_on;
        logic vco_on;
    } gate_t;

    // Master-to-bit-clock ratio for each rate code
    function automatic logic [DIV_W-1:0] bclk_ratio(rate_e r);
        case (r)
            RATE_384: return DIV_W'(6);
            RATE_512: return DIV_W'(8);
            default:  return DIV_W'(4);
        endcase
    endfunction

    // Codes whose source band is twice the master multiple
    function automatic logic pre_halve(rate_e r);
        return r == RATE_HALF512;
    endfunction

endpackage

// File: rtl/acs_lock_qual.sv
`timescale 1ns/1ps
module acs_lock_qual #(
    parameter int LOCK_CYC   = 32768,
    parameter int UNLOCK_CYC = 8192
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic pll_lock,
    output logic want_vco
);
    localparam int LIM_MAX = (LOCK_CYC > UNLOCK_CYC) ? LOCK_CYC : UNLOCK_CYC;
    localparam int CW      = $clog2(LIM_MAX + 1);

    logic [1:0]    sync_q;
    logic          lock_s;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    assign lock_s = sync_q[1];

    always_comb begin
        lim = want_vco ? CW'(UNLOCK_CYC - 1) : CW'(LOCK_CYC - 1);
    end

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            sync_q   <= '0;
            cnt_q    <= '0;
            want_vco <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pll_lock};
            if (lock_s != want_vco) begin
                if (cnt_q >= lim) begin
                    want_vco <= lock_s;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // R5: a move to the recovered clock follows a synchronized lock level
    a_r5_lock_held: assert property (@(posedge clk_ref) disable iff (rst)
        $rose(want_vco) |-> $past(lock_s))
        else $error("a_r5_lock_held");

    // R6: a move back follows a synchronized unlock level
    a_r6_unlock_held: assert property (@(posedge clk_ref) disable iff (rst)
        $fell(want_vco) |-> !$past(lock_s))
        else $error("a_r6_unlock_held");

endmodule

// File: rtl/acs_clk_mux.sv
`timescale 1ns/1ps
module acs_clk_mux (
    input  logic clk_ref,
    input  logic clk_vco,
    input  logic rst,
    input  logic want_vco,
    output logic clk_out,
    output logic vco_on
);
    import acs_pkg::*;

    gate_t gate;
    logic  ref_s1;
    logic  vco_s1;

    // Reference side: opens only after the recovered gate is seen closed
    always_ff @(negedge clk_ref) begin
        if (rst) begin
            ref_s1      <= 1'b0;
            gate.ref_on <= 1'b0;
        end else begin
            ref_s1      <= !want_vco && !gate.vco_on;
            gate.ref_on <= ref_s1;
        end
    end

    // Recovered side: opens only after the reference gate is seen closed
    always_ff @(negedge clk_vco) begin
        if (rst) begin
            vco_s1      <= 1'b0;
            gate.vco_on <= 1'b0;
        end else begin
            vco_s1      <= want_vco && !gate.ref_on;
            gate.vco_on <= vco_s1;
        end
    end

    assign clk_out = (clk_ref & gate.ref_on) | (clk_vco & gate.vco_on);
    assign vco_on  = gate.vco_on;

    // R7: break-before-make, the gates never overlap
    always_comb begin
        if (!rst) begin
            a_r7_no_overlap: assert (!(gate.ref_on && gate.vco_on))
                else $error("a_r7_no_overlap");
        end
    end

endmodule

// File: rtl/acs_divider.sv
`timescale 1ns/1ps
module acs_divider (
    input  logic               clk_core,
    input  logic               rst,
    input  logic               vco_on,
    input  acs_pkg::rate_e     rate,
    output acs_pkg::frame_clk_t fclk
);
    import acs_pkg::*;

    localparam int LR_HALF = LR_BITS / 2;

    logic [DIV_W-1:0] ratio;
    logic [DIV_W-1:0] bit_q, bit_nxt;
    logic [LR_W-1:0]  lr_q, lr_nxt;
    logic             wrap;
    logic             src_q;

    always_comb begin
        ratio   = bclk_ratio(rate);
        wrap    = bit_q >= (ratio - 1'b1);
        bit_nxt = wrap ? '0 : bit_q + 1'b1;
        if (wrap) begin
            lr_nxt = (lr_q == LR_W'(LR_BITS - 1)) ? '0 : lr_q + 1'b1;
        end else begin
            lr_nxt = lr_q;
        end
    end

    always_ff @(posedge clk_core) begin
        src_q <= vco_on;
        if (rst || (vco_on != src_q)) begin
            bit_q      <= '0;
            lr_q       <= '0;
            fclk.bclk  <= 1'b1;
            fclk.lrclk <= 1'b1;
        end else begin
            bit_q      <= bit_nxt;
            lr_q       <= lr_nxt;
            fclk.bclk  <= bit_nxt < (ratio >> 1);
            fclk.lrclk <= lr_nxt < LR_W'(LR_HALF);
        end
    end

    // R3: the word clock moves only on a rising bit clock edge
    a_r3_lr_on_bclk_rise: assert property (@(posedge clk_core) disable iff (rst)
        ($changed(fclk.lrclk) && !$changed(src_q)) |-> (fclk.bclk && !$past(fclk.bclk)))
        else $error("a_r3_lr_on_bclk_rise");

    // R10: both frame clocks restart high after a source change
    a_r10_restart_high: assert property (@(posedge clk_core) disable iff (rst)
        $changed(src_q) |-> (fclk.bclk && fclk.lrclk))
        else $error("a_r10_restart_high");

endmodule

// File: rtl/audio_clk_sel.sv
`timescale 1ns/1ps
module audio_clk_sel #(
    parameter int LOCK_CYC   = 32768,
    parameter int UNLOCK_CYC = 8192
) (
    input  logic       clk_ref,
    input  logic       clk_vco,
    input  logic       rst,
    input  logic       pll_lock,
    input  logic [1:0] rate_sel,
    input  logic       half_en,
    input  logic       inv_en,
    output logic       mclk,
    output logic       bclk,
    output logic       lrclk,
    output logic       on_vco
);
    import acs_pkg::*;

    rate_e      rate;
    logic       want_vco;
    logic       mux_clk;
    logic       pre_q;
    logic       core_clk;
    logic       post_q;
    frame_clk_t fclk;

    assign rate = rate_e'(rate_sel);

    acs_lock_qual #(
        .LOCK_CYC   (LOCK_CYC),
        .UNLOCK_CYC (UNLOCK_CYC)
    ) u_qual (
        .clk_ref  (clk_ref),
        .rst      (rst),
        .pll_lock (pll_lock),
        .want_vco (want_vco)
    );

    acs_clk_mux u_mux (
        .clk_ref  (clk_ref),
        .clk_vco  (clk_vco),
        .rst      (rst),
        .want_vco (want_vco),
        .clk_out  (mux_clk),
        .vco_on   (on_vco)
    );

    // Band halving for the 512fs/2 code
    always_ff @(posedge mux_clk) begin
        if (rst) pre_q <= 1'b0;
        else     pre_q <= ~pre_q;
    end

    assign core_clk = pre_halve(rate) ? pre_q : mux_clk;

    // Optional output halving, master clock only
    always_ff @(posedge core_clk) begin
        if (rst) post_q <= 1'b0;
        else     post_q <= ~post_q;
    end

    acs_divider u_div (
        .clk_core (core_clk),
        .rst      (rst),
        .vco_on   (on_vco),
        .rate     (rate),
        .fclk     (fclk)
    );

    assign mclk  = (half_en ? post_q : core_clk) ^ inv_en;
    assign bclk  = fclk.bclk;
    assign lrclk = fclk.lrclk;

    // R11: the status only rises while the recovered source is requested
    a_r11_status_follows: assert property (@(posedge clk_ref) disable iff (rst)
        $rose(on_vco) |-> want_vco)
        else $error("a_r11_status_follows");

endmodule

// File: tb/audio_clk_sel_bench.sv
`timescale 1ns/1ps
module audio_clk_sel_bench;

    logic       clk_ref = 1'b0;
    logic       clk_vco = 1'b0;
    logic       rst = 1'b1;
    logic       pll_lock = 1'b0;
    logic [1:0] rate_sel = 2'b01;
    logic       half_en = 1'b0;
    logic       inv_en = 1'b0;
    logic       mclk, bclk, lrclk, on_vco;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 0;

    audio_clk_sel #(.LOCK_CYC(40), .UNLOCK_CYC(10)) u_audio_clk_sel (
        .clk_ref  (clk_ref),
        .clk_vco  (clk_vco),
        .rst      (rst),
        .pll_lock (pll_lock),
        .rate_sel (rate_sel),
        .half_en  (half_en),
        .inv_en   (inv_en),
        .mclk     (mclk),
        .bclk     (bclk),
        .lrclk    (lrclk),
        .on_vco   (on_vco)
    );

    always #10 clk_ref = ~clk_ref;          // 50 MHz reference
    initial begin
        #4;
        forever #7 clk_vco = ~clk_vco;      // 14 ns recovered clock
    end

    typedef struct packed {
        logic        lock;
        logic [1:0]  rate;
        logic        half;
        logic        inv;
        logic [15:0] t_m;
        logic [15:0] t_b;
        logic [15:0] t_l;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 2'b01, 1'b0, 1'b0, 16'd20, 16'd80,  16'd5120},
        '{1'b0, 2'b11, 1'b0, 1'b0, 16'd20, 16'd160, 16'd10240},
        '{1'b1, 2'b01, 1'b0, 1'b0, 16'd14, 16'd56,  16'd3584},
        '{1'b1, 2'b00, 1'b0, 1'b0, 16'd28, 16'd112, 16'd7168},
        '{1'b1, 2'b10, 1'b0, 1'b0, 16'd14, 16'd84,  16'd5376},
        '{1'b1, 2'b11, 1'b1, 1'b0, 16'd28, 16'd112, 16'd7168},
        '{1'b0, 2'b00, 1'b1, 1'b0, 16'd80, 16'd160, 16'd10240},
        '{1'b1, 2'b01, 1'b1, 1'b1, 16'd28, 16'd56,  16'd3584}
    };

    // Shortest master clock pulse monitor
    bit      mon_on = 0;
    bit      mon_first = 1;
    realtime last_edge = 0.0;
    realtime min_w = 1.0e9;

    always @(mclk) begin
        if (mon_on) begin
            if (!mon_first && ($realtime - last_edge) < min_w)
                min_w = $realtime - last_edge;
            mon_first = 0;
            last_edge = $realtime;
        end
    end

    task automatic check_real(input string tag, input real act, input real exp, input real tol);
        n_checks++;
        if ((act - exp) > tol || (exp - act) > tol) begin
            n_fails++;
            $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic period_of(input int which, output real p);
        realtime t0;
        case (which)
            0: begin @(posedge mclk);  t0 = $realtime; @(posedge mclk);  end
            1: begin @(posedge bclk);  t0 = $realtime; @(posedge bclk);  end
            default: begin @(posedge lrclk); t0 = $realtime; @(posedge lrclk); end
        endcase
        p = $realtime - t0;
    endtask

    task automatic drive(input logic lk, input logic [1:0] rs, input logic h, input logic iv);
        @(negedge clk_ref);
        pll_lock = lk;
        rate_sel = rs;
        half_en  = h;
        inv_en   = iv;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #5_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        real p;
        realtime t0;

        // R12: reset state
        repeat (20) @(negedge clk_ref);
        rst = 1'b0;
        repeat (10) @(negedge clk_ref);
        check_bit("R12 on_vco after reset", on_vco, 1'b0);
        period_of(0, p);
        check_real("R12 R4 mclk from reference", p, 20.0, 0.5);

        // Vector table: R1 R2 R3 R4 R8 R11
        for (int i = 0; i < 8; i++) begin
            drive(VECS[i].lock, VECS[i].rate, VECS[i].half, VECS[i].inv);
            #3000;
            @(posedge lrclk);
            period_of(0, p);
            check_real($sformatf("R1 R8 mclk period vec%0d", i), p, real'(VECS[i].t_m), 0.5);
            period_of(1, p);
            check_real($sformatf("R2 bclk period vec%0d", i), p, real'(VECS[i].t_b), 0.5);
            period_of(2, p);
            check_real($sformatf("R3 lrclk period vec%0d", i), p, real'(VECS[i].t_l), 0.5);
            check_bit($sformatf("R4 R11 on_vco vec%0d", i), on_vco, VECS[i].lock);
        end

        // R5 / R6: lock qualification and dropout hold-off
        drive(1'b0, 2'b01, 1'b0, 1'b0);
        #3000;
        drive(1'b1, 2'b01, 1'b0, 1'b0);
        repeat (20) @(negedge clk_ref);
        check_bit("R5 still on reference before qualification", on_vco, 1'b0);
        repeat (60) @(negedge clk_ref);
        check_bit("R5 on recovered after qualification", on_vco, 1'b1);
        pll_lock = 1'b0;
        repeat (5) @(negedge clk_ref);
        pll_lock = 1'b1;
        repeat (20) @(negedge clk_ref);
        check_bit("R6 short dropout ignored", on_vco, 1'b1);
        pll_lock = 1'b0;
        repeat (5) @(negedge clk_ref);
        check_bit("R6 held before unlock interval", on_vco, 1'b1);
        repeat (30) @(negedge clk_ref);
        check_bit("R6 R4 back on reference", on_vco, 1'b0);

        // R10: divider restart phase after switching to recovered clock
        #2000;
        drive(1'b1, 2'b01, 1'b0, 1'b0);
        @(posedge on_vco);
        t0 = $realtime;
        @(negedge lrclk);
        check_real("R10 lrclk falls 32 bclk after restart", $realtime - t0, 1799.0, 1.0);

        // R7: shortest pulse across several changeovers
        #3000;
        mon_first = 1;
        mon_on = 1;
        for (int k = 0; k < 4; k++) begin
            drive(k[0] ? 1'b1 : 1'b0, 2'b01, 1'b0, 1'b0);
            #3000;
        end
        mon_on = 0;
        check_real("R7 min pulse width", (min_w < 7.0) ? min_w : 7.0, 7.0, 0.1);

        // R9: inversion seen just after a rising bit clock edge
        drive(1'b1, 2'b01, 1'b0, 1'b0);
        #3000;
        @(posedge bclk);
        #2;
        check_bit("R9 mclk high after bclk rise", mclk, 1'b1);
        drive(1'b1, 2'b01, 1'b0, 1'b1);
        #500;
        @(posedge bclk);
        #2;
        check_bit("R9 mclk low after bclk rise when inverted", mclk, 1'b0);

        finish_run();
    end

endmodule